// File: doc/BRIEF.md
# Nibble-Step Table CRC Engine

This block computes a reflected (right-shifting) cyclic redundancy check over a stream of bytes. It does not hard-wire a polynomial. A 16-entry table of 32-bit words is written through a small write port while the engine is idle. Each entry holds the effect of four right-shift steps of the chosen polynomial on a 4-bit value. Because of this, the same hardware handles 32-bit, 16-bit or other polynomial orders. For orders below 32, the result sits in the low-order bits.

A run begins with a start command. The command carries a 32-bit seed value and a 16-bit byte count, which may be anywhere from 0 to 65,535. Bytes then arrive over a valid/ready handshake. Each accepted byte is folded into the low 8 bits of the running value and then takes two table steps, so the engine accepts at most one byte every two cycles. When the last byte has been processed, the final value is presented together with a one-cycle completion pulse. The value then stays on the output until the next start. A long stream can be split into pieces by passing one run's result as the next run's seed.

Top module: `crc_nib_engine`

## Requirements
- R1: After reset, `busy`, `done` and `in_ready` are 0 and `crc_out` is 0. Every table entry is 0.
- R2: A `start` seen while `busy` is 0 with a nonzero `byte_len` loads `init_crc` and sets `busy`. In the next cycle `in_ready` is 1.
- R3: Each accepted byte is XORed into bits 7:0 of the running value. Then the step v = (v >> 4) XOR table[v[3:0]] is applied twice. With table[n] equal to four reflected shift steps of polynomial P applied to n, the result equals eight single-bit steps (shift right, insert 0, XOR P when the lost bit is 1).
- R4: In the cycle after a byte is accepted, `in_ready` is 0. The input rate is therefore at most one byte per two cycles.
- R5: `done` is high for exactly one cycle. That cycle follows the second table step of the last byte, which is two cycles after the final byte is accepted. `crc_out` keeps the result after `done` until the next accepted `start`.
- R6: A `start` with `byte_len` = 0 raises `done` in the next cycle, with `crc_out` equal to `init_crc`.
- R7: Table writes (`tbl_we`, entry `tbl_waddr`) take effect only while `busy` is 0. A write issued in the same cycle as an accepted `start` is used by that run. A write issued while `busy` is 1 changes nothing.
- R8: A `start` issued while `busy` is 1 is ignored and does not disturb the run in progress.
- R9: Splitting a stream into two runs gives the same result as one run over the whole stream, provided the second run is seeded with the first run's result.
- R10: While `in_ready` is 1 and `in_valid` is 0, `in_data` is ignored and the running value does not change.
- R11: The polynomial is set only by the table contents. The 32-bit reflected polynomials and 16-bit polynomials (result in bits 15:0) both match the bit-serial rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 4 | Table entry index |
| tbl_wdata | input | 32 | Table entry value |
| start | input | 1 | Start a run |
| init_crc | input | 32 | Seed value for the run |
| byte_len | input | 16 | Number of bytes in the run |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine can accept a byte |
| busy | output | 1 | Run in progress, including the completion cycle |
| done | output | 1 | One-cycle completion pulse |
| crc_out | output | 32 | Running or final CRC value |

## Verification
Two functions can coincide in one cycle: a table write and a start command. The bench issues both in the same idle cycle. Before that cycle, the entry being written has been deliberately corrupted, so the result matches the bit-serial model only if the write landed before the first table lookup. The bench also drives a start and a table write with bogus values in the middle of a run. It judges them dropped when that run's result still matches the model and when a following run on the same table also matches.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_STEP = 2'd2,
        ST_FIN  = 2'd3
    } crc_st_e;
endpackage

// File: rtl/crc_nib_table.sv
module crc_nib_table #(
    parameter int CRC_W = 32,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [NIB_W-1:0] waddr,
    input  logic [CRC_W-1:0] wdata,
    input  logic [NIB_W-1:0] raddr,
    output logic [CRC_W-1:0] rdata
);
    localparam int ENT_N = 1 << NIB_W;

    logic [CRC_W-1:0] ent_q [ENT_N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT_N; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[waddr] <= wdata;
        end
    end

    assign rdata = ent_q[raddr];
endmodule

// File: rtl/crc_nib_step.sv
module crc_nib_step #(
    parameter int CRC_W = 32,
    parameter int NIB_W = 4
) (
    input  logic [CRC_W-1:0] cur,
    input  logic [CRC_W-1:0] entry,
    output logic [CRC_W-1:0] nxt
);
    // one table step: drop the low nibble, fold in its precomputed effect
    assign nxt = (cur >> NIB_W) ^ entry;
endmodule

// File: rtl/crc_nib_engine.sv
module crc_nib_engine
    import crc_nib_pkg::*;
#(
    parameter int CRC_W  = 32,
    parameter int LEN_W  = 16,
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [NIB_W-1:0]  tbl_waddr,
    input  logic [CRC_W-1:0]  tbl_wdata,
    input  logic              start,
    input  logic [CRC_W-1:0]  init_crc,
    input  logic [LEN_W-1:0]  byte_len,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic [CRC_W-1:0]  crc_out
);
    localparam int STEPS = DATA_W / NIB_W;
    localparam int PH_W  = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        crc_st_e          st;
        logic [CRC_W-1:0] crc;
        logic [LEN_W-1:0] left;
        logic [PH_W-1:0]  ph;
    } regs_t;

    regs_t r_d, r_q;

    logic [CRC_W-1:0] mix;
    logic [CRC_W-1:0] step_in;
    logic [CRC_W-1:0] step_out;
    logic [CRC_W-1:0] tbl_rd;
    logic             tbl_wr_ok;

    assign mix       = r_q.crc ^ {{(CRC_W-DATA_W){1'b0}}, in_data};
    assign step_in   = (r_q.st == ST_TAKE) ? mix : r_q.crc;
    assign tbl_wr_ok = tbl_we && (r_q.st == ST_IDLE);

    crc_nib_table #(.CRC_W(CRC_W), .NIB_W(NIB_W)) i_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_wr_ok),
        .waddr (tbl_waddr),
        .wdata (tbl_wdata),
        .raddr (step_in[NIB_W-1:0]),
        .rdata (tbl_rd)
    );

    crc_nib_step #(.CRC_W(CRC_W), .NIB_W(NIB_W)) i_step (
        .cur   (step_in),
        .entry (tbl_rd),
        .nxt   (step_out)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.crc  = init_crc;
                    r_d.left = byte_len;
                    r_d.ph   = '0;
                    r_d.st   = (byte_len == '0) ? ST_FIN : ST_TAKE;
                end
            end
            ST_TAKE: begin
                if (in_valid) begin
                    r_d.crc  = step_out;
                    r_d.left = r_q.left - 1'b1;
                    r_d.ph   = PH_W'(STEPS - 1);
                    if (STEPS > 1)
                        r_d.st = ST_STEP;
                    else
                        r_d.st = (r_q.left == LEN_W'(1)) ? ST_FIN : ST_TAKE;
                end
            end
            ST_STEP: begin
                r_d.crc = step_out;
                r_d.ph  = r_q.ph - 1'b1;
                if (r_q.ph == PH_W'(1))
                    r_d.st = (r_q.left == '0) ? ST_FIN : ST_TAKE;
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.crc  <= '0;
            r_q.left <= '0;
            r_q.ph   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.st == ST_TAKE);
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = (r_q.st == ST_FIN);
    assign crc_out  = r_q.crc;
endmodule

// File: rtl/crc_nib_engine_chk.sv
module crc_nib_engine_chk #(
    parameter int CRC_W = 32,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CRC_W-1:0] init_crc,
    input logic [LEN_W-1:0] byte_len,
    input logic             in_valid,
    input logic             in_ready,
    input logic             busy,
    input logic             done,
    input logic [CRC_W-1:0] crc_out
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_len != '0) |=> (busy && in_ready));

    // R2
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    // R4
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(crc_out));

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_len == '0) |=> (done && crc_out == $past(init_crc)));

    // R10
    stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(crc_out));
endmodule

bind crc_nib_engine crc_nib_engine_chk #(.CRC_W(CRC_W), .LEN_W(LEN_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .init_crc (init_crc),
    .byte_len (byte_len),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done),
    .crc_out  (crc_out)
);

// File: tb/test_crc_nib_engine.sv
module test_crc_nib_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_waddr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        start = 1'b0;
    logic [31:0] init_crc = '0;
    logic [15:0] byte_len = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, busy, done;
    logic [31:0] crc_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    crc_nib_engine i_crc_nib_engine (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
        .tbl_wdata(tbl_wdata), .start(start), .init_crc(init_crc),
        .byte_len(byte_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .busy(busy), .done(done), .crc_out(crc_out)
    );

    // poly, init, len, seed, stall cycles before each byte
    localparam int NV = 6;
    localparam logic [95:0] VEC [NV] = '{
        96'hEDB88320_FFFFFFFF_0010_01_00,
        96'hEDB88320_00000000_0007_5A_02,
        96'h82F63B78_FFFFFFFF_0021_C3_01,
        96'h0000A001_00000000_000A_11_00,
        96'h0000A001_0000FFFF_0001_7E_03,
        96'hEDB88320_12345678_012C_99_00
    };

    function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] b, logic [31:0] p);
        c = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
        return c;
    endfunction

    function automatic logic [31:0] tbl_entry(int n, logic [31:0] p);
        logic [31:0] c = 32'(n);
        for (int k = 0; k < 4; k++) c = c[0] ? ((c >> 1) ^ p) : (c >> 1);
        return c;
    endfunction

    function automatic logic [7:0] data_byte(logic [7:0] seed, int idx, bit asc);
        if (asc) return 8'h31 + idx[7:0];
        return (seed ^ (idx[7:0] * 8'd29) ^ idx[15:8]) + 8'd3;
    endfunction

    function automatic logic [31:0] exp_crc(logic [31:0] init, int len, logic [7:0] seed,
                                            int base, bit asc, logic [31:0] p);
        logic [31:0] c = init;
        for (int i = 0; i < len; i++) c = ref_byte(c, data_byte(seed, base + i, asc), p);
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic load_table(logic [31:0] p);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_waddr = 4'(i); tbl_wdata = tbl_entry(i, p);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Runs one job. fix_ent >= 0 writes table entry fix_ent on the start cycle.
    task automatic run_job(logic [31:0] init, int len, logic [7:0] seed, int stall, int base,
                           bit asc, bit disturb, int fix_ent, logic [31:0] fix_val,
                           output logic [31:0] res);
        @(negedge clk);
        start = 1'b1; init_crc = init; byte_len = 16'(len);
        if (fix_ent >= 0) begin
            tbl_we = 1'b1; tbl_waddr = 4'(fix_ent); tbl_wdata = fix_val;
        end
        @(negedge clk);
        start = 1'b0; tbl_we = 1'b0;
        for (int i = 0; i < len; i++) begin
            int t = 0;
            if (disturb && i == 1) begin
                start = 1'b1; init_crc = 32'hBAD0BAD0; byte_len = 16'h0;
                tbl_we = 1'b1; tbl_waddr = 4'h3; tbl_wdata = 32'hFFFF0000;
                @(negedge clk);
                start = 1'b0; tbl_we = 1'b0;
            end
            while (!in_ready && t < 50) begin @(negedge clk); t++; end
            if (t >= 50) check("R2 ready timeout", 32'(in_ready), 32'd1);
            for (int s = 0; s < stall; s++) begin
                in_valid = 1'b0; in_data = 8'hA5 ^ 8'(s);
                @(negedge clk);
            end
            in_valid = 1'b1; in_data = data_byte(seed, base + i, asc);
            @(negedge clk);
            in_valid = 1'b0;
            if (i == 0) check("R4 ready low after accept", 32'(in_ready), 32'd0);
        end
        if (len > 0) begin
            check("R5 done not early", 32'(done), 32'd0);
            @(negedge clk);
        end
        check("R5 done pulse", 32'(done), 32'd1);
        res = crc_out;
        @(negedge clk);
        check("R5 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] res, r1, r2, whole, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 in_ready", 32'(in_ready), 32'd0);
        check("R1 crc_out", crc_out, 32'h0);

        // R3 R11 R10: vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [31:0] p  = VEC[v][95:64];
            logic [31:0] in = VEC[v][63:32];
            int          ln = int'(VEC[v][31:16]);
            logic [7:0]  sd = VEC[v][15:8];
            int          st = int'(VEC[v][7:0]);
            load_table(p);
            run_job(in, ln, sd, st, 0, 1'b0, 1'b0, -1, 32'h0, res);
            check($sformatf("R3 R11 R10 vector %0d", v), res, exp_crc(in, ln, sd, 0, 1'b0, p));
        end

        // R3: well-known check string with the reflected 32-bit polynomial
        load_table(32'hEDB88320);
        run_job(32'hFFFFFFFF, 9, 8'h0, 0, 0, 1'b1, 1'b0, -1, 32'h0, res);
        check("R3 check string", res, 32'h340BC6D9);

        // R5: result held after done
        held = crc_out;
        repeat (5) @(negedge clk);
        check("R5 hold", crc_out, held);

        // R6: zero length
        run_job(32'hDEADBEEF, 0, 8'h0, 0, 0, 1'b0, 1'b0, -1, 32'h0, res);
        check("R6 zero length result", res, 32'hDEADBEEF);
        check("R6 idle after", 32'(busy), 32'd0);

        // R9: chained runs
        run_job(32'hFFFFFFFF, 11, 8'h4C, 0, 0, 1'b0, 1'b0, -1, 32'h0, whole);
        run_job(32'hFFFFFFFF, 5, 8'h4C, 0, 0, 1'b0, 1'b0, -1, 32'h0, r1);
        run_job(r1, 6, 8'h4C, 1, 5, 1'b0, 1'b0, -1, 32'h0, r2);
        check("R9 chained equals whole", r2, whole);
        check("R9 whole vs model", whole, exp_crc(32'hFFFFFFFF, 11, 8'h4C, 0, 1'b0, 32'hEDB88320));

        // R7 R8: start and table write during a run are dropped
        run_job(32'h0F0F0F0F, 8, 8'h27, 0, 0, 1'b0, 1'b1, -1, 32'h0, res);
        check("R8 start while busy ignored", res, exp_crc(32'h0F0F0F0F, 8, 8'h27, 0, 1'b0, 32'hEDB88320));
        run_job(32'hFFFFFFFF, 12, 8'h63, 0, 0, 1'b0, 1'b0, -1, 32'h0, res);
        check("R7 table intact after busy write", res, exp_crc(32'hFFFFFFFF, 12, 8'h63, 0, 1'b0, 32'hEDB88320));

        // R7: write on the start cycle is used by that run
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = 4'h9; tbl_wdata = 32'h13579BDF;
        @(negedge clk);
        tbl_we = 1'b0;
        run_job(32'hFFFFFFFF, 20, 8'hE1, 0, 0, 1'b0, 1'b0, 9, tbl_entry(9, 32'hEDB88320), res);
        check("R7 write with start", res, exp_crc(32'hFFFFFFFF, 20, 8'hE1, 0, 1'b0, 32'hEDB88320));

        finish_up();
    end
endmodule